// File: doc/BRIEF.md
# Serial Register Bus Slave Bridge

This block is the slave end of a narrow serial register bus. A requester raises a request line and streams a short header on a two-bit data lane. The header holds one operation bit and a 17-bit register address. The bridge turns each header into a single-cycle access on a plain parallel register port. On a read, the fetched word goes back over a two-bit output lane while acknowledge is held high. On a write, the data word follows the header on the same input lane, and acknowledge then pulses for one cycle. The register word width is a parameter, 32 or 8 bits. The serial side and the parallel side share one clock, and reset is asynchronous.

The control is one state machine with eight states. ST_IDLE waits for the request. On a request it goes to ST_HDR and takes the first lane pair. ST_HDR collects the header. If the request drops it goes back to ST_IDLE (abort). After the ninth pair it goes to ST_RD_STROBE when the operation bit is 0, or to ST_WDATA when it is 1. ST_WDATA collects DATA_W/2 data pairs. If the request drops it goes back to ST_IDLE (abort). After the last pair it goes to ST_WR_STROBE. ST_RD_STROBE always goes to ST_RD_LATCH, which always goes to ST_RD_SHIFT. ST_RD_SHIFT stays for DATA_W/2 cycles and then goes back to ST_IDLE. ST_WR_STROBE always goes to ST_WR_ACK, which always goes back to ST_IDLE.

Top module: `srb_bridge`

## Requirements
- R1: Outside a response, `ack_o`, `sdo_o`, `reg_rd_o` and `reg_wr_o` are all 0. This includes the time while reset is held.
- R2: A header takes 9 cycles with `req_i` high. In cycle 0, lane 0 carries the operation bit (0 = read, 1 = write) and lane 1 carries address bit 0. In cycle c (c = 1 to 8), lane 0 carries address bit 2c-1 and lane 1 carries address bit 2c. The assembled address appears on `reg_addr_o` during the strobe.
- R3: For a read, `reg_rd_o` is high for exactly one cycle: the cycle after the edge that samples the ninth header pair. `reg_rd_o` and `reg_wr_o` are never high together.
- R4: `reg_rdata_i` is sampled at the end of the cycle after the read strobe. `ack_o` then stays high for exactly DATA_W/2 consecutive cycles: 16 cycles when DATA_W is 32, and 4 cycles when DATA_W is 8.
- R5: During acknowledge cycle k (k counts from 0), `sdo_o[0]` is read data bit 2k and `sdo_o[1]` is read data bit 2k+1.
- R6: A write header is followed by DATA_W/2 data cycles with `req_i` still high. The data is sent least significant pair first, with lane 0 as the lower bit. `reg_wr_o` then pulses for one cycle with the address and the full data word.
- R7: After a write strobe, `ack_o` is high for exactly one cycle: the cycle that follows the strobe.
- R8: If `req_i` is low in any header cycle after the first, or in any write data cycle, the transfer is dropped. No strobe and no acknowledge follow, and the next request is accepted as a fresh transfer.
- R9: From the end of the header to the end of the acknowledge, `req_i` and `sdi_i` have no effect on the response.
- R10: Raising `arst` clears `ack_o` and `sdo_o` at once, without waiting for a clock edge, even in the middle of a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the serial and parallel sides |
| arst | input | 1 | Asynchronous reset, active high |
| req_i | input | 1 | Transfer request |
| sdi_i | input | 2 | Serial input lane pair |
| sdo_o | output | 2 | Serial output lane pair (read data) |
| ack_o | output | 1 | Acknowledge |
| reg_addr_o | output | 17 | Register address, valid while a strobe is high |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | DATA_W | Write data, valid with the write strobe |
| reg_rdata_i | input | DATA_W | Read data, valid the cycle after the read strobe |

## Verification
Call the edge that samples the ninth header pair E8. The read strobe is due right after E8. Acknowledge is then low for one cycle and high after each of the edges E10 to E9+DATA_W/2. For a write, the strobe follows the edge that samples the last data pair, and the single acknowledge cycle follows one edge later. The bench drives one lane pair on each falling edge. It then counts falling edges from the last pair and samples each of these results in exactly the cycle it is due, including the first cycle after each window ends. Aborts are checked over a long quiet window, and the asynchronous reset is checked half a nanosecond after it rises, before any clock edge.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int ADDR_W   = 17;
    localparam int LANE_W   = 2;
    localparam int HDR_BITS = ADDR_W + 1;
    localparam int HDR_CYC  = HDR_BITS / LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_WDATA,
        ST_RD_STROBE,
        ST_RD_LATCH,
        ST_RD_SHIFT,
        ST_WR_STROBE,
        ST_WR_ACK
    } srb_state_e;
endpackage

// File: rtl/srb_deser.sv
module srb_deser #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         arst,
    input  logic         en,
    input  logic [1:0]   lane,
    output logic [W-1:0] q
);
    generate
        if (W % 2 != 0) begin : g_bad_width
            $error("srb_deser width must be even");
        end
    endgenerate

    // New pairs enter at the top so the first pair ends in bits [1:0].
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            q <= '0;
        end else if (en) begin
            q <= {lane, q[W-1:2]};
        end
    end
endmodule

// File: rtl/srb_ser.sv
module srb_ser #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         arst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [1:0]   lane
);
    logic [W-1:0] sr;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            sr <= '0;
        end else if (load) begin
            sr <= din;
        end else if (shift) begin
            sr <= {2'b00, sr[W-1:2]};
        end
    end

    assign lane = sr[1:0];

    // R5: the first pair shown after a load is the lowest pair of the word
    p_first_pair_r5: assert property (@(posedge clk) disable iff (arst)
        load |=> (lane == $past(din[1:0])));
endmodule

// File: rtl/srb_ctrl.sv
module srb_ctrl
    import srb_pkg::*;
#(
    parameter int BEATS = 16
) (
    input  logic clk,
    input  logic arst,
    input  logic req,
    input  logic op_bit,
    output logic hdr_en,
    output logic dat_en,
    output logic rd_stb,
    output logic wr_stb,
    output logic tx_load,
    output logic tx_shift,
    output logic tx_active,
    output logic ack
);
    localparam int MAXC = (HDR_CYC > BEATS) ? HDR_CYC : BEATS;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] LAST_HDR  = CNT_W'(HDR_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

    srb_state_e       state, nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             op_q, op_nxt;

    // State register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            op_q  <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            op_q  <= op_nxt;
        end
    end

    // Next state
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        op_nxt  = op_q;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    nxt     = ST_HDR;
                    cnt_nxt = CNT_W'(1);
                    op_nxt  = op_bit;
                end
            end
            ST_HDR: begin
                if (!req) begin
                    nxt     = ST_IDLE;
                    cnt_nxt = '0;
                end else if (cnt == LAST_HDR) begin
                    nxt     = op_q ? ST_WDATA : ST_RD_STROBE;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_WDATA: begin
                if (!req) begin
                    nxt     = ST_IDLE;
                    cnt_nxt = '0;
                end else if (cnt == LAST_BEAT) begin
                    nxt     = ST_WR_STROBE;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_RD_STROBE: nxt = ST_RD_LATCH;
            ST_RD_LATCH: begin
                nxt     = ST_RD_SHIFT;
                cnt_nxt = '0;
            end
            ST_RD_SHIFT: begin
                if (cnt == LAST_BEAT) begin
                    nxt     = ST_IDLE;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_WR_STROBE: nxt = ST_WR_ACK;
            ST_WR_ACK:    nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        hdr_en    = req && (state == ST_IDLE || state == ST_HDR);
        dat_en    = req && (state == ST_WDATA);
        rd_stb    = (state == ST_RD_STROBE);
        wr_stb    = (state == ST_WR_STROBE);
        tx_load   = (state == ST_RD_LATCH);
        tx_shift  = (state == ST_RD_SHIFT);
        tx_active = (state == ST_RD_SHIFT);
        ack       = (state == ST_RD_SHIFT) || (state == ST_WR_ACK);
    end

    // Acknowledge run-length counter for the checks below
    logic [CNT_W:0] ack_run;
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            ack_run <= '0;
        end else if (ack) begin
            ack_run <= ack_run + 1'b1;
        end else begin
            ack_run <= '0;
        end
    end

    p_rd_pulse_r3: assert property (@(posedge clk) disable iff (arst)
        rd_stb |=> (!rd_stb && tx_load && !ack));
    p_latch_then_ack_r4: assert property (@(posedge clk) disable iff (arst)
        tx_load |=> ack);
    p_ack_len_r4: assert property (@(posedge clk) disable iff (arst)
        ack_run <= (CNT_W+1)'(BEATS));
    p_wr_ack_next_r7: assert property (@(posedge clk) disable iff (arst)
        wr_stb |=> (ack && !wr_stb));
    p_wr_ack_single_r7: assert property (@(posedge clk) disable iff (arst)
        (state == ST_WR_ACK) |=> !ack);
    p_abort_r8: assert property (@(posedge clk) disable iff (arst)
        ((state == ST_HDR || state == ST_WDATA) && !req) |=> (state == ST_IDLE));
endmodule

// File: rtl/srb_bridge.sv
module srb_bridge
    import srb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              arst,
    input  logic              req_i,
    input  logic [1:0]        sdi_i,
    output logic [1:0]        sdo_o,
    output logic              ack_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_rd_o,
    output logic              reg_wr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    localparam int BEATS = DATA_W / LANE_W;

    generate
        if (DATA_W != 32 && DATA_W != 8) begin : g_bad_data_w
            $error("srb_bridge DATA_W must be 32 or 8");
        end
    endgenerate

    logic                hdr_en, dat_en, tx_load, tx_shift, tx_active;
    logic [HDR_BITS-1:0] hdr_q;
    logic [DATA_W-1:0]   dat_q;
    logic [1:0]          tx_lane;

    srb_ctrl #(.BEATS(BEATS)) u_ctrl (
        .clk       (clk),
        .arst      (arst),
        .req       (req_i),
        .op_bit    (sdi_i[0]),
        .hdr_en    (hdr_en),
        .dat_en    (dat_en),
        .rd_stb    (reg_rd_o),
        .wr_stb    (reg_wr_o),
        .tx_load   (tx_load),
        .tx_shift  (tx_shift),
        .tx_active (tx_active),
        .ack       (ack_o)
    );

    srb_deser #(.W(HDR_BITS)) u_hdr (
        .clk  (clk),
        .arst (arst),
        .en   (hdr_en),
        .lane (sdi_i),
        .q    (hdr_q)
    );

    srb_deser #(.W(DATA_W)) u_wdat (
        .clk  (clk),
        .arst (arst),
        .en   (dat_en),
        .lane (sdi_i),
        .q    (dat_q)
    );

    srb_ser #(.W(DATA_W)) u_tx (
        .clk   (clk),
        .arst  (arst),
        .load  (tx_load),
        .shift (tx_shift),
        .din   (reg_rdata_i),
        .lane  (tx_lane)
    );

    assign reg_addr_o  = hdr_q[HDR_BITS-1:1];
    assign reg_wdata_o = dat_q;
    assign sdo_o       = tx_active ? tx_lane : 2'b00;

    p_quiet_r1: assert property (@(posedge clk) disable iff (arst)
        !ack_o |-> (sdo_o == 2'b00));
    p_rd_op_r2: assert property (@(posedge clk) disable iff (arst)
        reg_rd_o |-> !hdr_q[0]);
    p_wr_op_r6: assert property (@(posedge clk) disable iff (arst)
        reg_wr_o |-> hdr_q[0]);
    p_excl_r3: assert property (@(posedge clk) disable iff (arst)
        !(reg_rd_o && reg_wr_o));
endmodule

// File: tb/srb_bridge_test.sv
`timescale 1ns/1ps
module srb_bridge_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        arst;
    logic        req32, req8;
    logic [1:0]  sdi32, sdi8, sdo32, sdo8;
    logic        ack32, ack8, rd32, rd8, wr32, wr8;
    logic [16:0] addr32, addr8;
    logic [31:0] wd32, rdd32;
    logic [7:0]  wd8, rdd8;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    srb_bridge #(.DATA_W(32)) uut (
        .clk(clk), .arst(arst), .req_i(req32), .sdi_i(sdi32), .sdo_o(sdo32),
        .ack_o(ack32), .reg_addr_o(addr32), .reg_rd_o(rd32), .reg_wr_o(wr32),
        .reg_wdata_o(wd32), .reg_rdata_i(rdd32));

    srb_bridge #(.DATA_W(8)) uut_n (
        .clk(clk), .arst(arst), .req_i(req8), .sdi_i(sdi8), .sdo_o(sdo8),
        .ack_o(ack8), .reg_addr_o(addr8), .reg_rd_o(rd8), .reg_wr_o(wr8),
        .reg_wdata_o(wd8), .reg_rdata_i(rdd8));

    // Register file models: read data valid the cycle after the strobe
    logic [31:0] mem32 [0:63];
    logic [7:0]  mem8  [0:63];
    logic [31:0] sh32  [0:63];
    logic [7:0]  sh8   [0:63];

    function automatic logic [31:0] scr(logic [16:0] a);
        return (32'(a) * 32'd40503) ^ 32'h5A3C_96E1;
    endfunction

    always @(posedge clk) begin
        if (rd32) rdd32 <= mem32[addr32[5:0]] ^ scr(addr32);
        if (wr32) mem32[addr32[5:0]] <= wd32 ^ scr(addr32);
        if (rd8)  rdd8  <= mem8[addr8[5:0]] ^ scr(addr8)[7:0];
        if (wr8)  mem8[addr8[5:0]] <= wd8 ^ scr(addr8)[7:0];
    end

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drv(bit nw, logic r, logic [1:0] d);
        if (nw) begin req8 = r; sdi8 = d; end
        else begin req32 = r; sdi32 = d; end
    endtask

    function automatic logic ackv(bit nw);       return nw ? ack8 : ack32; endfunction
    function automatic logic [1:0] sdov(bit nw); return nw ? sdo8 : sdo32; endfunction
    function automatic logic rdv(bit nw);        return nw ? rd8 : rd32; endfunction
    function automatic logic wrv(bit nw);        return nw ? wr8 : wr32; endfunction
    function automatic logic [16:0] addrv(bit nw); return nw ? addr8 : addr32; endfunction
    function automatic logic [31:0] wdv(bit nw); return nw ? 32'(wd8) : wd32; endfunction

    function automatic logic [31:0] expected(bit nw, logic [16:0] a);
        if (nw) return 32'(sh8[a[5:0]] ^ scr(a)[7:0]);
        return sh32[a[5:0]] ^ scr(a);
    endfunction

    // Read: header on 9 falling edges, strobe after E8, ack after E10..E9+n
    task automatic do_read(bit nw, logic [16:0] a, bit hold);
        int n = nw ? 4 : 16;
        logic [17:0] h = {a, 1'b0};
        logic [31:0] exp = expected(nw, a);
        logic [31:0] got = '0;
        for (int c = 0; c < 9; c++) begin
            @(negedge clk); drv(nw, 1'b1, h[2*c +: 2]);
        end
        @(negedge clk);
        if (hold) drv(nw, 1'b1, 2'b11); else drv(nw, 1'b0, 2'b00);
        chk("R3", "read strobe", 32'(rdv(nw)), 1);
        chk("R2", "address", 32'(addrv(nw)), 32'(a));
        chk("R3", "no write strobe", 32'(wrv(nw)), 0);
        @(negedge clk);
        if (hold) drv(nw, 1'b1, 2'b10);
        chk("R3", "strobe one cycle", 32'(rdv(nw)), 0);
        chk("R4", "ack low in latch cycle", 32'(ackv(nw)), 0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 0) drv(nw, 1'b0, 2'b00);
            chk(hold ? "R9" : "R4", "ack high", 32'(ackv(nw)), 1);
            chk(hold ? "R9" : "R5", "lane pair", 32'(sdov(nw)), 32'(exp[2*k +: 2]));
            got[2*k +: 2] = sdov(nw);
        end
        @(negedge clk);
        chk("R4", "ack ends", 32'(ackv(nw)), 0);
        chk("R1", "idle lane", 32'(sdov(nw)), 0);
        chk("R5", "read word", got, exp);
    endtask

    task automatic do_write(bit nw, logic [16:0] a, logic [31:0] d);
        int n = nw ? 4 : 16;
        logic [17:0] h = {a, 1'b1};
        logic [31:0] dm = nw ? {24'h0, d[7:0]} : d;
        for (int c = 0; c < 9; c++) begin
            @(negedge clk); drv(nw, 1'b1, h[2*c +: 2]);
        end
        for (int c = 0; c < n; c++) begin
            @(negedge clk); drv(nw, 1'b1, dm[2*c +: 2]);
        end
        @(negedge clk); drv(nw, 1'b0, 2'b00);
        chk("R6", "write strobe", 32'(wrv(nw)), 1);
        chk("R6", "write address", 32'(addrv(nw)), 32'(a));
        chk("R6", "write data", wdv(nw), dm);
        chk("R7", "no ack with strobe", 32'(ackv(nw)), 0);
        @(negedge clk);
        chk("R7", "ack after strobe", 32'(ackv(nw)), 1);
        chk("R6", "write strobe one cycle", 32'(wrv(nw)), 0);
        @(negedge clk);
        chk("R7", "ack single cycle", 32'(ackv(nw)), 0);
        if (nw) sh8[a[5:0]] = d[7:0] ^ scr(a)[7:0];
        else sh32[a[5:0]] = d ^ scr(a);
    endtask

    task automatic do_abort(bit nw, int k, logic [16:0] a, bit op);
        int n = nw ? 4 : 16;
        logic [17:0] h = {a, op};
        bit seen = 0;
        for (int c = 0; c < k; c++) begin
            @(negedge clk); drv(nw, 1'b1, (c < 9) ? h[2*c +: 2] : 2'b01);
        end
        @(negedge clk); drv(nw, 1'b0, 2'b00);
        for (int i = 0; i < 2 * n + 12; i++) begin
            @(negedge clk);
            if (ackv(nw) || rdv(nw) || wrv(nw) || sdov(nw) != 2'b00) seen = 1;
        end
        chk("R8", $sformatf("abort after %0d pairs", k), 32'(seen), 0);
    endtask

    task automatic do_reset_mid();
        logic [17:0] h = {17'h1_2345, 1'b0};
        for (int c = 0; c < 9; c++) begin
            @(negedge clk); drv(1'b0, 1'b1, h[2*c +: 2]);
        end
        @(negedge clk); drv(1'b0, 1'b0, 2'b00);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk("R4", "ack high before reset", 32'(ack32), 1);
        #1 arst = 1'b1;
        #0.5;
        chk("R10", "ack cleared by reset", 32'(ack32), 0);
        chk("R10", "lane cleared by reset", 32'(sdo32), 0);
        @(negedge clk);
        @(negedge clk);
        arst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog R1: actual hung expected finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem32[i] = '0; mem8[i] = '0; sh32[i] = '0; sh8[i] = '0;
        end
        rdd32 = '0; rdd8 = '0;
        arst = 1'b1;
        req32 = 0; req8 = 0; sdi32 = 0; sdi8 = 0;
        repeat (3) @(negedge clk);
        chk("R1", "reset ack", 32'(ack32 | ack8), 0);
        chk("R1", "reset lanes", 32'({sdo32, sdo8}), 0);
        chk("R1", "reset strobes", 32'({rd32, wr32, rd8, wr8}), 0);
        arst = 1'b0;
        @(negedge clk);

        for (int w = 0; w < 2; w++) begin
            bit nw = (w == 1);
            do_read(nw, 17'h0, 0);
            do_read(nw, 17'h1_FFFF, 0);
            for (int b = 0; b < 17; b++) do_read(nw, 17'(1) << b, 0);
            for (int i = 0; i < 8; i++) begin
                logic [16:0] a = 17'(i * 4603 + 77);
                logic [31:0] d = 32'(i) * 32'h1357_9BDF + 32'hA5A5_0F0F;
                do_write(nw, a, d);
                do_read(nw, a, 0);
            end
            do_read(nw, 17'h0_ABCD, 1);
            for (int k = 1; k < 9; k++) do_abort(nw, k, 17'h1_5A5A, k[0]);
            do_abort(nw, 9 + (nw ? 2 : 7), 17'h0_0F0F, 1'b1);
            do_read(nw, 17'h0_0F0F, 0);
            do_read(nw, 17'h1_5A5A, 0);
        end
        do_reset_mid();
        do_read(1'b0, 17'h0_3C3C, 0);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule